// File: doc/BRIEF.md
# SPI DMA Request and Receive-Count Controller

This block sits between an SPI shift engine (with its transmit and receive FIFOs) and an external DMA controller. It watches the FIFO fill levels and raises a transmit or receive DMA request whenever the matching FIFO can accept or supply a byte. A request is raised only when the SPI is on, the global DMA switch is on and that direction's own switch is on. Each request is held until the DMA controller acknowledges it. After the acknowledge the request drops for one cycle, so the FIFO level can settle before the request is recomputed.

The block also picks which FIFO interrupts reach the CPU. While DMA is switched on, the ordinary level interrupts are masked. Transmit underrun and receive overflow still get through, and a receive-flush setting masks overflow.

In master receive-count mode, a counter tallies received bytes against a programmed target. The transfer-permit output to the shift engine falls once the target is met, and a one-cycle done pulse marks that moment. Outside count mode, the permit simply follows whether transmit data is waiting. Bytes already queued therefore still go out after DMA is switched off.

Top module: `spi_dma_ctl`

## Requirements
- R1: No DMA request is ever raised unless the SPI enable (control register address 0, bit 0) and the global DMA enable (DMA register address 1, bit 0) are both 1.
- R2: Address 1 bit 1 gates the transmit request and bit 2 gates the receive request. The two are independent, and either or both may be set. Clearing a gate drops its request on the next clock edge.
- R3: With its gates open, the transmit request rises one clock after the transmit level is below the FIFO depth (8). The receive request rises one clock after the receive level is nonzero.
- R4: A raised request stays high, whatever the FIFO level, until its acknowledge is sampled. It is low in the cycle after the acknowledge and is recomputed from the level on the following edge.
- R5: The transmit level interrupt (level at most 2) and the receive level interrupt (level at least 1) each follow the SPI enable one clock later. Both are held low while the global DMA enable is 1.
- R6: A transmit underrun event or a receive overflow event while the SPI is enabled raises its interrupt for one cycle, one clock later, whether or not DMA is enabled.
- R7: Control bit 2 (receive flush) drives the flush output and suppresses the receive overflow interrupt.
- R8: Count mode is active when control bits 0, 1 (master) and 3 (count mode) are all 1. In count mode, each received-byte pulse advances the counter, up to the target held at address 2. The transfer permit is high only while the counter is below the target.
- R9: The received-byte counter returns to zero when the target register is written or while the SPI enable is 0.
- R10: A one-cycle done pulse is output one clock after the received-byte pulse that brings the counter up to the target.
- R11: Outside count mode, the transfer permit equals SPI enable AND (transmit level nonzero). It combines the inputs in the same cycle and does not depend on the DMA enables.
- R12: After reset, all requests, interrupts, the done pulse, the flush output and the transfer permit are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 DMA, 2 target count |
| reg_wdata | input | 8 | Register write data |
| tx_level | input | 4 | Entries in the transmit FIFO (0..8) |
| rx_level | input | 4 | Entries in the receive FIFO (0..8) |
| tx_underrun | input | 1 | Transmit underrun event pulse |
| rx_overflow | input | 1 | Receive overflow event pulse |
| rx_byte | input | 1 | One byte received by the shift engine |
| tx_dack | input | 1 | Transmit DMA acknowledge |
| rx_dack | input | 1 | Receive DMA acknowledge |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| rx_fifo_flush | output | 1 | Receive FIFO flush control |
| xfer_allow | output | 1 | Shift engine may start another byte |
| rx_done | output | 1 | Target count reached (one-cycle pulse) |
| irq_tx | output | 1 | Transmit level interrupt |
| irq_rx | output | 1 | Receive level interrupt |
| irq_txur | output | 1 | Transmit underrun interrupt |
| irq_rxof | output | 1 | Receive overflow interrupt |

## Verification
A register write takes effect on the edge that samples it. The requests, interrupts and done pulse are registered, so each follows its cause by exactly one more edge. The transfer permit is combinational from the register state and the transmit level. The bench drives every input just after a rising edge and samples one time unit after the next rising edge, so each registered result is checked in its first valid cycle. The permit is checked one time unit after a level change, with no edge in between. Acknowledge tests check both the low cycle right after the acknowledge and the recomputed value one edge later.

// File: rtl/spi_dma_pkg.sv
package spi_dma_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DMA   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd2;

    // control register bit positions
    localparam int CTRL_SPI_EN   = 0;
    localparam int CTRL_MASTER   = 1;
    localparam int CTRL_RX_FLUSH = 2;
    localparam int CTRL_CNT_MODE = 3;

    // DMA register bit positions
    localparam int DMA_GLOBAL = 0;
    localparam int DMA_TX     = 1;
    localparam int DMA_RX     = 2;

    localparam int NUM_DIR = 2;
    localparam int DIR_TX  = 0;
    localparam int DIR_RX  = 1;

    typedef struct packed {
        logic spi_en;
        logic master;
        logic rx_flush;
        logic cnt_mode;
        logic dma_en;
        logic tx_en;
        logic rx_en;
    } cfg_t;

endpackage

// File: rtl/spi_dma_regs.sv
module spi_dma_regs
    import spi_dma_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output cfg_t                cfg_o,
    output logic [CNT_W-1:0]    count_o,
    output logic                count_wr_o
);

    typedef struct packed {
        cfg_t             cfg;
        logic [CNT_W-1:0] count;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            unique case (addr_i)
                ADDR_CTRL: begin
                    st_d.cfg.spi_en   = wdata_i[CTRL_SPI_EN];
                    st_d.cfg.master   = wdata_i[CTRL_MASTER];
                    st_d.cfg.rx_flush = wdata_i[CTRL_RX_FLUSH];
                    st_d.cfg.cnt_mode = wdata_i[CTRL_CNT_MODE];
                end
                ADDR_DMA: begin
                    st_d.cfg.dma_en = wdata_i[DMA_GLOBAL];
                    st_d.cfg.tx_en  = wdata_i[DMA_TX];
                    st_d.cfg.rx_en  = wdata_i[DMA_RX];
                end
                ADDR_COUNT: begin
                    st_d.count = wdata_i[CNT_W-1:0];
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o      = st_q.cfg;
    assign count_o    = st_q.count;
    assign count_wr_o = wr_i && (addr_i == ADDR_COUNT);

    AST_COUNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_COUNT) |=> (count_o == $past(wdata_i[CNT_W-1:0]))); // R9

endmodule

// File: rtl/spi_dma_req.sv
module spi_dma_req (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_i,
    input  logic want_i,
    input  logic ack_i,
    output logic req_o
);

    typedef struct packed {
        logic req;
    } req_st_t;

    req_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!gate_i) begin
            st_d.req = 1'b0;
        end else if (st_q.req && ack_i) begin
            st_d.req = 1'b0;
        end else if (st_q.req) begin
            st_d.req = 1'b1;
        end else begin
            st_d.req = want_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_o = st_q.req;

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> $past(gate_i)); // R1
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> !req_o); // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i && gate_i) |=> req_o); // R4
    AST_GATE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_i |=> !req_o); // R2

endmodule

// File: rtl/spi_dma_rxcnt.sv
module spi_dma_rxcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             clear_i,
    input  logic             byte_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             allow_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    below;
    logic    bump;

    always_comb begin
        below = (st_q.cnt < target_i);
        bump  = active_i && byte_i && below;
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (bump) begin
            st_d.cnt  = st_q.cnt + ONE;
            st_d.done = ((st_q.cnt + ONE) == target_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign allow_o = below;
    assign done_o  = st_q.done;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= target_i); // R8
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.cnt == '0)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !allow_o || clear_i || $past(clear_i)); // R10

endmodule

// File: rtl/spi_dma_irq.sv
module spi_dma_irq #(
    parameter int LVL_W      = 4,
    parameter int TX_IRQ_LVL = 2,
    parameter int RX_IRQ_LVL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_en_i,
    input  logic             dma_en_i,
    input  logic             rx_flush_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic             txur_evt_i,
    input  logic             rxof_evt_i,
    output logic             irq_tx_o,
    output logic             irq_rx_o,
    output logic             irq_txur_o,
    output logic             irq_rxof_o
);

    localparam logic [LVL_W-1:0] TX_THR = LVL_W'(TX_IRQ_LVL);
    localparam logic [LVL_W-1:0] RX_THR = LVL_W'(RX_IRQ_LVL);

    typedef struct packed {
        logic tx;
        logic rx;
        logic txur;
        logic rxof;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tx   = spi_en_i && !dma_en_i && (tx_level_i <= TX_THR);
        st_d.rx   = spi_en_i && !dma_en_i && (rx_level_i >= RX_THR);
        st_d.txur = spi_en_i && txur_evt_i;
        st_d.rxof = spi_en_i && rxof_evt_i && !rx_flush_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_tx_o   = st_q.tx;
    assign irq_rx_o   = st_q.rx;
    assign irq_txur_o = st_q.txur;
    assign irq_rxof_o = st_q.rxof;

    AST_TX_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en_i |=> !irq_tx_o); // R5
    AST_RX_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en_i |=> !irq_rx_o); // R5
    AST_UNDERRUN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en_i && txur_evt_i) |=> irq_txur_o); // R6
    AST_OVERFLOW_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush_i |=> !irq_rxof_o); // R7

endmodule

// File: rtl/spi_dma_ctl.sv
module spi_dma_ctl
    import spi_dma_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 8,
    parameter int TX_IRQ_LVL = 2,
    parameter int RX_IRQ_LVL = 1,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              tx_underrun,
    input  logic              rx_overflow,
    input  logic              rx_byte,
    input  logic              tx_dack,
    input  logic              rx_dack,
    output logic              tx_dreq,
    output logic              rx_dreq,
    output logic              rx_fifo_flush,
    output logic              xfer_allow,
    output logic              rx_done,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_txur,
    output logic              irq_rxof
);

    localparam logic [LVL_W-1:0] DEPTH_LVL = LVL_W'(FIFO_DEPTH);

    cfg_t               cfg;
    logic [CNT_W-1:0]   target;
    logic               target_wr;
    logic               cnt_active;
    logic               cnt_clear;
    logic               cnt_allow;
    logic [NUM_DIR-1:0] dir_gate;
    logic [NUM_DIR-1:0] dir_want;
    logic [NUM_DIR-1:0] dir_ack;
    logic [NUM_DIR-1:0] dir_req;

    spi_dma_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .cfg_o      (cfg),
        .count_o    (target),
        .count_wr_o (target_wr)
    );

    always_comb begin
        dir_gate[DIR_TX] = cfg.spi_en && cfg.dma_en && cfg.tx_en;
        dir_gate[DIR_RX] = cfg.spi_en && cfg.dma_en && cfg.rx_en;
        dir_want[DIR_TX] = (tx_level < DEPTH_LVL);
        dir_want[DIR_RX] = (rx_level != '0);
        dir_ack[DIR_TX]  = tx_dack;
        dir_ack[DIR_RX]  = rx_dack;
    end

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        spi_dma_req u_req (
            .clk    (clk),
            .rst_n  (rst_n),
            .gate_i (dir_gate[g]),
            .want_i (dir_want[g]),
            .ack_i  (dir_ack[g]),
            .req_o  (dir_req[g])
        );
    end

    assign tx_dreq = dir_req[DIR_TX];
    assign rx_dreq = dir_req[DIR_RX];

    assign cnt_active = cfg.spi_en && cfg.master && cfg.cnt_mode;
    assign cnt_clear  = target_wr || !cfg.spi_en;

    spi_dma_rxcnt #(
        .CNT_W (CNT_W)
    ) u_rxcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (cnt_active),
        .clear_i  (cnt_clear),
        .byte_i   (rx_byte),
        .target_i (target),
        .allow_o  (cnt_allow),
        .done_o   (rx_done)
    );

    assign xfer_allow    = cnt_active ? cnt_allow : (cfg.spi_en && (tx_level != '0));
    assign rx_fifo_flush = cfg.rx_flush;

    spi_dma_irq #(
        .LVL_W      (LVL_W),
        .TX_IRQ_LVL (TX_IRQ_LVL),
        .RX_IRQ_LVL (RX_IRQ_LVL)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_en_i   (cfg.spi_en),
        .dma_en_i   (cfg.dma_en),
        .rx_flush_i (cfg.rx_flush),
        .tx_level_i (tx_level),
        .rx_level_i (rx_level),
        .txur_evt_i (tx_underrun),
        .rxof_evt_i (rx_overflow),
        .irq_tx_o   (irq_tx),
        .irq_rx_o   (irq_rx),
        .irq_txur_o (irq_txur),
        .irq_rxof_o (irq_rxof)
    );

    AST_STOP_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> !xfer_allow || !cnt_active || $past(cnt_clear) || cnt_clear); // R8
    AST_DRAIN_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_active && cfg.spi_en && tx_level != '0) |-> xfer_allow); // R11

endmodule

// File: tb/sim_spi_dma_ctl.sv
module sim_spi_dma_ctl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [3:0] tx_level = '0;
    logic [3:0] rx_level = '0;
    logic       tx_underrun = 1'b0;
    logic       rx_overflow = 1'b0;
    logic       rx_byte = 1'b0;
    logic       tx_dack = 1'b0;
    logic       rx_dack = 1'b0;
    logic       tx_dreq, rx_dreq, rx_fifo_flush, xfer_allow, rx_done;
    logic       irq_tx, irq_rx, irq_txur, irq_rxof;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    spi_dma_ctl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .tx_level(tx_level), .rx_level(rx_level),
        .tx_underrun(tx_underrun), .rx_overflow(rx_overflow), .rx_byte(rx_byte),
        .tx_dack(tx_dack), .rx_dack(rx_dack), .tx_dreq(tx_dreq), .rx_dreq(rx_dreq),
        .rx_fifo_flush(rx_fifo_flush), .xfer_allow(xfer_allow), .rx_done(rx_done),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_txur(irq_txur), .irq_rxof(irq_rxof)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R12 tx_dreq", tx_dreq, 1'b0);
        check("R12 rx_dreq", rx_dreq, 1'b0);
        check("R12 xfer_allow", xfer_allow, 1'b0);
        check("R12 rx_done", rx_done, 1'b0);
        check("R12 flush", rx_fifo_flush, 1'b0);
        check("R12 irqs", irq_tx | irq_rx | irq_txur | irq_rxof, 1'b0);
    endtask

    task automatic t_gate();
        wr(2'd0, 8'h01);
        tx_level = 4'd3; rx_level = 4'd2;
        wr(2'd1, 8'h06); step();
        check("R1 tx no global", tx_dreq, 1'b0);
        check("R1 rx no global", rx_dreq, 1'b0);
        wr(2'd1, 8'h03); step();
        check("R2 tx only tx", tx_dreq, 1'b1);
        check("R2 rx only tx", rx_dreq, 1'b0);
        wr(2'd1, 8'h05); step();
        check("R2 tx gate closed", tx_dreq, 1'b0);
        check("R2 rx only rx", rx_dreq, 1'b1);
        wr(2'd1, 8'h07); step();
        check("R2 both tx", tx_dreq, 1'b1);
        check("R2 both rx", rx_dreq, 1'b1);
        wr(2'd0, 8'h00); step();
        check("R1 spi off tx", tx_dreq, 1'b0);
        check("R1 spi off rx", rx_dreq, 1'b0);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
    endtask

    task automatic t_tx_req();
        rx_level = 4'd0; tx_level = 4'd8;
        wr(2'd1, 8'h03); step();
        check("R3 tx full", tx_dreq, 1'b0);
        tx_level = 4'd7; step();
        check("R3 tx space", tx_dreq, 1'b1);
        tx_level = 4'd8; step();
        check("R4 held until ack", tx_dreq, 1'b1);
        tx_dack = 1'b1; tx_level = 4'd7; step(); tx_dack = 1'b0;
        check("R4 low after ack", tx_dreq, 1'b0);
        step();
        check("R4 recomputed space", tx_dreq, 1'b1);
        tx_dack = 1'b1; tx_level = 4'd8; step(); tx_dack = 1'b0;
        check("R4 low after ack 2", tx_dreq, 1'b0);
        step();
        check("R3 recomputed full", tx_dreq, 1'b0);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_rx_req();
        tx_level = 4'd0; rx_level = 4'd0;
        wr(2'd1, 8'h05); step();
        check("R3 rx empty", rx_dreq, 1'b0);
        rx_level = 4'd1; step();
        check("R3 rx data", rx_dreq, 1'b1);
        rx_dack = 1'b1; rx_level = 4'd0; step(); rx_dack = 1'b0;
        check("R4 rx low after ack", rx_dreq, 1'b0);
        step();
        check("R4 rx recomputed empty", rx_dreq, 1'b0);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_irq();
        tx_level = 4'd2; rx_level = 4'd1; step();
        check("R5 tx irq no dma", irq_tx, 1'b1);
        check("R5 rx irq no dma", irq_rx, 1'b1);
        tx_level = 4'd3; rx_level = 4'd0; step();
        check("R5 tx irq above thr", irq_tx, 1'b0);
        check("R5 rx irq empty", irq_rx, 1'b0);
        tx_level = 4'd2; rx_level = 4'd1;
        wr(2'd1, 8'h01); step();
        check("R5 tx irq masked", irq_tx, 1'b0);
        check("R5 rx irq masked", irq_rx, 1'b0);
        wr(2'd1, 8'h00); step();
        check("R5 tx irq back", irq_tx, 1'b1);
        tx_level = 4'd0; rx_level = 4'd0;
    endtask

    task automatic t_err_irq();
        wr(2'd1, 8'h07);
        tx_underrun = 1'b1; step(); tx_underrun = 1'b0;
        check("R6 underrun in dma", irq_txur, 1'b1);
        step();
        check("R6 underrun pulse ends", irq_txur, 1'b0);
        rx_overflow = 1'b1; step(); rx_overflow = 1'b0;
        check("R6 overflow in dma", irq_rxof, 1'b1);
        wr(2'd0, 8'h05);
        check("R7 flush out", rx_fifo_flush, 1'b1);
        rx_overflow = 1'b1; step(); rx_overflow = 1'b0;
        check("R7 overflow masked", irq_rxof, 1'b0);
        wr(2'd0, 8'h01);
        check("R7 flush off", rx_fifo_flush, 1'b0);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_count();
        tx_level = 4'd0;
        wr(2'd2, 8'd3);
        wr(2'd0, 8'h0B);
        check("R8 allow at start", xfer_allow, 1'b1);
        for (int i = 0; i < 3; i++) begin
            rx_byte = 1'b1; step(); rx_byte = 1'b0;
            if (i < 2) begin
                check("R10 no early done", rx_done, 1'b0);
                check("R8 allow below", xfer_allow, 1'b1);
            end else begin
                check("R10 done at target", rx_done, 1'b1);
                check("R8 stop at target", xfer_allow, 1'b0);
            end
        end
        step();
        check("R10 done one cycle", rx_done, 1'b0);
        rx_byte = 1'b1; step(); rx_byte = 1'b0;
        check("R8 extra byte no done", rx_done, 1'b0);
        check("R8 still stopped", xfer_allow, 1'b0);
    endtask

    task automatic t_clear();
        wr(2'd2, 8'd2);
        check("R9 target write clears", xfer_allow, 1'b1);
        rx_byte = 1'b1; step(); rx_byte = 1'b0;
        check("R9 one counted", rx_done, 1'b0);
        wr(2'd0, 8'h0A);
        check("R9 spi off no allow", xfer_allow, 1'b0);
        step();
        wr(2'd0, 8'h0B);
        check("R9 allow after reenable", xfer_allow, 1'b1);
        rx_byte = 1'b1; step(); rx_byte = 1'b0;
        check("R9 counted from zero", rx_done, 1'b0);
        rx_byte = 1'b1; step(); rx_byte = 1'b0;
        check("R9 done after two", rx_done, 1'b1);
    endtask

    task automatic t_drain();
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h00);
        tx_level = 4'd4; #1;
        check("R11 drain no dma", xfer_allow, 1'b1);
        tx_level = 4'd0; #1;
        check("R11 empty no allow", xfer_allow, 1'b0);
        wr(2'd1, 8'h07);
        tx_level = 4'd4; #1;
        check("R11 same with dma", xfer_allow, 1'b1);
        wr(2'd0, 8'h00);
        check("R11 spi off", xfer_allow, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!ended) begin
            ended = 1'b1;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_gate();
        t_tx_req();
        t_rx_req();
        t_irq();
        t_err_irq();
        t_count();
        t_clear();
        t_drain();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule